// File: doc/BRIEF.md
# Configurable Request Arbiter

This block chooses one winner among a parameterized number of requesters and reports it three ways: a one-hot grant vector, a binary index and a valid flag. All three come from registers. The winner is chosen either by fixed priority or by rotating priority. A second parameter sets how long a winner keeps its grant:

- **No hold:** the arbiter decides again on every clock.
- **Hold on request:** the grant stays while the winning request stays high.
- **Hold on acknowledge:** the grant stays until the acknowledge bit at the winner's position is seen.

A shared resource uses it to pick its next user. Each user raises a request bit. The one-hot grant can drive a select, and the index can steer a multiplexer. In acknowledge mode, the resource pulses the winner's acknowledge bit when it is finished with that user.

Top module: `req_arbiter`

## Requirements
- R1: While reset is asserted (rst_n low), the grant vector is all zeros, the index is 0 and grant_valid is 0.
- R2: The grant vector has at most one bit set. grant_valid is 1 exactly when a bit is set, and grant_idx then gives the position of that bit (bit i set means index i).
- R3: With hold mode none or hold-on-request, a clock edge at which the request vector is all zeros leaves grant_valid at 0 and the grant vector at zero.
- R4: In fixed mode, among the active requests the one with the lowest index wins.
- R5: In rotating mode, the search starts at the index just above the previous winner and wraps past the top index to 0. After reset, the search starts at index 0.
- R6: Outputs are registered. Requests present at a clock edge are reflected in the outputs only after that edge.
- R7: With hold mode none, every clock edge is a fresh arbitration, whatever the previous grant was.
- R8: With hold-on-request, the grant stays unchanged while the granted request bit remains high. In the cycle that bit drops, a fresh arbitration takes place.
- R9: With hold-on-acknowledge, the grant stays unchanged until the acknowledge bit at the granted index is high. This holds even if the granted request drops, and acknowledge bits at other positions have no effect. In the cycle the matching acknowledge is seen, a fresh arbitration takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_REQ | Request vector, one bit per requester |
| ack_i | input | N_REQ | Acknowledge vector, used in hold-on-acknowledge mode |
| grant_o | output | N_REQ | One-hot grant vector |
| grant_idx_o | output | IDX_W | Binary index of the granted requester |
| grant_valid_o | output | 1 | A grant is active |

## Verification
A corrupted rotation pointer shows up at the next fresh arbitration as a grant to the wrong requester. Sequences that step the winner through every index, including the wrap from the top index back to 0, expose it within one cycle of each release. A wrong hold decision shows up at the next edge: the grant changes while the winner still requests or while no acknowledge has come, or it sticks after a release or a matching acknowledge. The bench drives each of these cases on three instances, one per mode combination, and compares the outputs one edge after every input change.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    PICK_FIXED = 1'b0,
    PICK_RR    = 1'b1
  } pick_mode_e;

  typedef enum logic [1:0] {
    HOLD_NONE    = 2'd0,
    HOLD_RELEASE = 2'd1,
    HOLD_ACK     = 2'd2
  } hold_mode_e;
endpackage

// File: rtl/arb_lowest_enc.sv
// Lowest-index priority encoder: one-hot, binary index, any-set flag.
module arb_lowest_enc #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] oh,
  output logic [W-1:0] idx,
  output logic         any
);
  function automatic logic [W-1:0] f_first_set(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = W'(i);
    end
    return r;
  endfunction

  always_comb begin
    any = |vec;
    idx = f_first_set(vec);
    oh  = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/arb_rr_window.sv
// Keeps only the requests strictly above the previous winner.
module arb_rr_window #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] last_idx,
  input  logic [N-1:0] vec,
  output logic [N-1:0] upper
);
  function automatic logic [N-1:0] f_above_mask(input logic [W-1:0] ptr);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i > int'(ptr));
    return m;
  endfunction

  assign upper = vec & f_above_mask(last_idx);
endmodule

// File: rtl/arb_hold_ctl.sv
// Decides whether the current grant is retained this cycle.
module arb_hold_ctl #(
  parameter arb_pkg::hold_mode_e HOLD = arb_pkg::HOLD_RELEASE,
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic         granted,
  input  logic [W-1:0] cur_idx,
  input  logic [N-1:0] req,
  input  logic [N-1:0] ack,
  output logic         keep
);
  generate
    if (HOLD == arb_pkg::HOLD_RELEASE) begin : g_release
      logic unused_ack;
      assign unused_ack = ^ack;
      assign keep = granted && req[cur_idx];
    end else if (HOLD == arb_pkg::HOLD_ACK) begin : g_ack
      logic unused_req;
      assign unused_req = ^req;
      assign keep = granted && !ack[cur_idx];
    end else begin : g_none
      logic unused_in;
      assign unused_in = ^{req, ack, cur_idx, granted};
      assign keep = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/req_arbiter.sv
module req_arbiter #(
  parameter int unsigned         N_REQ = 4,
  parameter arb_pkg::pick_mode_e PICK  = arb_pkg::PICK_RR,
  parameter arb_pkg::hold_mode_e HOLD  = arb_pkg::HOLD_RELEASE,
  localparam int unsigned        IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] ack_i,
  output logic [N_REQ-1:0] grant_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             grant_valid_o
);
  logic [N_REQ-1:0] gnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q;

  // named internal events
  logic             keep_grant;
  logic             rearb;
  logic [N_REQ-1:0] pick_oh;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;

  arb_hold_ctl #(.HOLD(HOLD), .N(N_REQ), .W(IDX_W)) u_hold (
    .granted (vld_q),
    .cur_idx (idx_q),
    .req     (req_i),
    .ack     (ack_i),
    .keep    (keep_grant)
  );

  assign rearb = !keep_grant;

  logic [N_REQ-1:0] all_oh;
  logic [IDX_W-1:0] all_idx;
  logic             all_any;

  arb_lowest_enc #(.N(N_REQ), .W(IDX_W)) u_enc_all (
    .vec (req_i),
    .oh  (all_oh),
    .idx (all_idx),
    .any (all_any)
  );

  generate
    if (PICK == arb_pkg::PICK_RR) begin : g_rr
      logic [IDX_W-1:0] last_q;
      logic [N_REQ-1:0] upper_req;
      logic [N_REQ-1:0] hi_oh;
      logic [IDX_W-1:0] hi_idx;
      logic             hi_any;

      arb_rr_window #(.N(N_REQ), .W(IDX_W)) u_win (
        .last_idx (last_q),
        .vec      (req_i),
        .upper    (upper_req)
      );

      arb_lowest_enc #(.N(N_REQ), .W(IDX_W)) u_enc_hi (
        .vec (upper_req),
        .oh  (hi_oh),
        .idx (hi_idx),
        .any (hi_any)
      );

      assign pick_oh  = hi_any ? hi_oh  : all_oh;
      assign pick_idx = hi_any ? hi_idx : all_idx;
      assign pick_any = all_any;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          last_q <= IDX_W'(N_REQ - 1);
        end else if (rearb && pick_any) begin
          last_q <= pick_idx;
        end
      end
    end else begin : g_fixed
      assign pick_oh  = all_oh;
      assign pick_idx = all_idx;
      assign pick_any = all_any;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
    end else if (rearb) begin
      gnt_q <= pick_oh;
      idx_q <= pick_idx;
      vld_q <= pick_any;
    end
  end

  assign grant_o       = gnt_q;
  assign grant_idx_o   = idx_q;
  assign grant_valid_o = vld_q;

  // R2: grant encoding consistency
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  a_r2_valid_any: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o == (grant_o != '0));
  a_r2_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> grant_o[grant_idx_o]);

  generate
    if (HOLD != arb_pkg::HOLD_ACK) begin : g_chk_idle
      a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> !grant_valid_o);
      a_r6_new_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !$stable(grant_o)) |-> (($past(req_i) & grant_o) != '0));
    end
    if (HOLD == arb_pkg::HOLD_RELEASE) begin : g_chk_rel
      a_r8_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && req_i[grant_idx_o]) |=> $stable(grant_o));
    end
    if (HOLD == arb_pkg::HOLD_ACK) begin : g_chk_ack
      a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !ack_i[grant_idx_o]) |=> $stable(grant_o));
    end
    if (PICK == arb_pkg::PICK_FIXED && HOLD == arb_pkg::HOLD_NONE) begin : g_chk_fix
      a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (($past(req_i) & (grant_o - N_REQ'(1))) == '0));
    end
  endgenerate
endmodule

// File: tb/sim_req_arbiter.sv
module sim_req_arbiter;
  import arb_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic       rst_n;
  logic [3:0] req_a, ack_a, req_b, ack_b, req_c, ack_c;
  logic [3:0] g_a, g_b, g_c;
  logic [1:0] i_a, i_b, i_c;
  logic       v_a, v_b, v_c;

  req_arbiter #(.N_REQ(4), .PICK(PICK_RR), .HOLD(HOLD_RELEASE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_a), .ack_i(ack_a),
    .grant_o(g_a), .grant_idx_o(i_a), .grant_valid_o(v_a));
  req_arbiter #(.N_REQ(4), .PICK(PICK_FIXED), .HOLD(HOLD_NONE)) u1 (
    .clk(clk), .rst_n(rst_n), .req_i(req_b), .ack_i(ack_b),
    .grant_o(g_b), .grant_idx_o(i_b), .grant_valid_o(v_b));
  req_arbiter #(.N_REQ(4), .PICK(PICK_RR), .HOLD(HOLD_ACK)) u2 (
    .clk(clk), .rst_n(rst_n), .req_i(req_c), .ack_i(ack_c),
    .grant_o(g_c), .grant_idx_o(i_c), .grant_valid_o(v_c));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // {request, expected grant} for the fixed, no-hold instance (R4, R7)
  localparam logic [7:0] FIX_TBL [9] = '{
    8'b0000_0000, 8'b1010_0010, 8'b1000_1000, 8'b1111_0001, 8'b1110_0010,
    8'b0110_0010, 8'b0100_0100, 8'b1100_0100, 8'b0011_0001
  };

  task automatic chk(string tag, logic [3:0] g, logic [1:0] ix, logic v, logic [3:0] eg);
    logic [1:0] eix;
    logic       ev;
    eix = 2'd0;
    for (int k = 0; k < 4; k++) if (eg[k]) eix = 2'(k);
    ev = |eg;
    n_cmp++;
    if (g !== eg || v !== ev || (ev && ix !== eix)) begin
      n_bad++;
      $display("FAIL %s (R2 encoding): gnt=%b idx=%0d vld=%b expected gnt=%b idx=%0d vld=%b",
               tag, g, ix, v, eg, eix, ev);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drv_a(logic [3:0] r);
    @(negedge clk); req_a = r;
  endtask
  task automatic drv_c(logic [3:0] r, logic [3:0] a);
    @(negedge clk); req_c = r; ack_c = a;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_a = '0; ack_a = '0; req_b = '0; ack_b = '0; req_c = '0; ack_c = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, with requests present
    @(negedge clk); req_a = 4'b1111; req_b = 4'b1111; req_c = 4'b1111;
    tick();
    chk("R1 u0 reset", g_a, i_a, v_a, 4'b0000);
    chk("R1 u1 reset", g_b, i_b, v_b, 4'b0000);
    chk("R1 u2 reset", g_c, i_c, v_c, 4'b0000);
    @(negedge clk); req_a = '0; req_b = '0; req_c = '0;
    rst_n = 1'b1;

    // R4 / R7: fixed priority, fresh decision every edge
    for (int t = 0; t < 9; t++) begin
      @(negedge clk); req_b = FIX_TBL[t][7:4];
      tick();
      chk($sformatf("R4 R7 table entry %0d", t), g_b, i_b, v_b, FIX_TBL[t][3:0]);
    end

    // R6: output does not move before the edge
    @(negedge clk); req_b = 4'b1000;
    #1 chk("R6 before edge", g_b, i_b, v_b, 4'b0001);
    tick();
    chk("R6 after edge", g_b, i_b, v_b, 4'b1000);
    // R3: no request
    @(negedge clk); req_b = 4'b0000;
    tick();
    chk("R3 u1 idle", g_b, i_b, v_b, 4'b0000);

    // R5 / R8: rotating with hold on request (u0)
    drv_a(4'b1111); tick(); chk("R5 start at 0", g_a, i_a, v_a, 4'b0001);
    drv_a(4'b1111); tick(); chk("R8 held while req", g_a, i_a, v_a, 4'b0001);
    drv_a(4'b1110); tick(); chk("R8 R5 release to 1", g_a, i_a, v_a, 4'b0010);
    drv_a(4'b1100); tick(); chk("R5 next 2", g_a, i_a, v_a, 4'b0100);
    drv_a(4'b1001); tick(); chk("R5 next 3", g_a, i_a, v_a, 4'b1000);
    drv_a(4'b0011); tick(); chk("R5 wrap to 0", g_a, i_a, v_a, 4'b0001);
    drv_a(4'b0000); tick(); chk("R3 u0 idle", g_a, i_a, v_a, 4'b0000);
    drv_a(4'b0010); tick(); chk("R5 after idle", g_a, i_a, v_a, 4'b0010);

    // R9: rotating with hold on acknowledge (u2)
    drv_c(4'b0110, 4'b0000); tick(); chk("R9 first grant", g_c, i_c, v_c, 4'b0010);
    drv_c(4'b0110, 4'b0100); tick(); chk("R9 other ack ignored", g_c, i_c, v_c, 4'b0010);
    drv_c(4'b0000, 4'b0000); tick(); chk("R9 held after req drop", g_c, i_c, v_c, 4'b0010);
    drv_c(4'b0101, 4'b0010); tick(); chk("R9 R5 ack moves to 2", g_c, i_c, v_c, 4'b0100);
    drv_c(4'b0101, 4'b0100); tick(); chk("R9 R5 ack wraps to 0", g_c, i_c, v_c, 4'b0001);
    drv_c(4'b0000, 4'b0001); tick(); chk("R9 ack with no req", g_c, i_c, v_c, 4'b0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule